// File: doc/BRIEF.md
# Gated Carrier Tone Generator

This block makes a square-wave signalling carrier of about 22 kHz by dividing the system clock. A control bit can turn the carrier on continuously. When that bit is clear, an asynchronous keying pin turns it on, so an external controller can shape bursts for pulse-width-keyed signalling. A transmit-select bit chooses which of two supply output paths is live. The carrier reaches the transmit path only, and only while that path is selected. A master enable turns everything off.

The divider is built for fast start-up. Each time the gate opens, it restarts at phase zero, so every burst begins with a full high half-period a fixed number of cycles after the keying edge. When the gate closes, the output drops low in the same cycle. The half-period length comes from the clock and tone frequency parameters.

Top module: `tone_gate_gen`

## Requirements
- R1: While reset is asserted, `tone_o` is 0. With `en_i` at 0, `tx_port_en_o` and `rx_port_en_o` are both 0.
- R2: While the gate stays open, `tone_o` alternates between HALF cycles high and HALF cycles low, giving a 50% duty cycle and a period of 2·HALF cycles.
- R3: HALF equals (CLK_HZ + TONE_HZ) / (2·TONE_HZ) in integer division, which is CLK_HZ / (2·TONE_HZ) rounded to the nearest cycle.
- R4: With `en_i`=1, `tx_sel_i`=1 and `tone_force_i`=1, the carrier runs continuously. `key_i` has no effect on it, on its phase, or on when it starts.
- R5: With `tone_force_i`=0, the gate is open only while `key_i`, delayed through SYNC_STAGES synchroniser flops (2 by default), is high.
- R6: Each opening of the gate restarts the divider. `tone_o` goes high at the first clock edge after the gate opens and stays high for a full HALF cycles. With 2 sync stages, this is the third rising edge after `key_i` rises.
- R7: In the cycle the gate closes, `tone_o` is 0. With 2 sync stages, this is after the second rising edge following the fall of `key_i`.
- R8: With `en_i`=0, `tone_o` is 0 and neither port enable is asserted.
- R9: `tx_port_en_o` = `en_i` AND `tx_sel_i`, and `rx_port_en_o` = `en_i` AND NOT `tx_sel_i`. `tone_o` is 0 whenever `tx_sel_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Master enable for the power paths |
| tone_force_i | input | 1 | Continuous-tone override; masks the keying pin |
| tx_sel_i | input | 1 | Selects the transmit output path |
| key_i | input | 1 | Asynchronous keying input |
| tone_o | output | 1 | Gated carrier square wave |
| tx_port_en_o | output | 1 | Transmit output path enable |
| rx_port_en_o | output | 1 | Receive output path enable |

## Verification
The bench builds the block with CLK_HZ=200 and TONE_HZ=20, so the half-period is 5 cycles. At that size a whole carrier period fits in ten samples, which allows three sweeps in a short run. The first covers all eight control-bit combinations with the keying pin both low and high. The second covers every keyed burst length from 1 to 25 cycles, including pulses shorter than the synchroniser delay and bursts that end at every phase of the carrier. The third checks the override with a keying pin that toggles throughout.

// File: rtl/tone_pkg.sv
package tone_pkg;

  // Divider half-period in clock cycles, rounded to nearest.
  function automatic int unsigned half_cycles(input int unsigned clk_hz,
                                              input int unsigned tone_hz);
    return (clk_hz + tone_hz) / (2 * tone_hz);
  endfunction

  // Carrier gate: path enabled, transmit selected, and forced or keyed.
  function automatic logic gate_open(input logic en, input logic tx_sel,
                                     input logic force_on, input logic key_s);
    return en & tx_sel & (force_on | key_s);
  endfunction

endpackage

// File: rtl/tone_key_sync.sv
module tone_key_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_i,
  output logic key_s_o
);
  localparam int unsigned SW = (STAGES < 2) ? 2 : STAGES;

  logic [SW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SW-2:0], key_i};
  end

  assign key_s_o = sh_q[SW-1];
endmodule

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int unsigned HALF = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic restart_o,
  output logic tone_o
);
  localparam int unsigned CW = (HALF > 2) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic          gate_q;
  logic [CW-1:0] cnt_q;
  logic          phase_q;

  assign restart_o = gate_i & ~gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= 1'b0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      gate_q <= gate_i;
      if (!gate_i) begin
        cnt_q   <= '0;
        phase_q <= 1'b0;
      end else if (restart_o) begin
        cnt_q   <= '0;
        phase_q <= 1'b1;
      end else if (cnt_q == LAST) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Output is gated combinationally so a closing gate silences it at once.
  assign tone_o = phase_q & gate_i;
endmodule

// File: rtl/tone_port_steer.sv
module tone_port_steer (
  input  logic en_i,
  input  logic tx_sel_i,
  output logic tx_en_o,
  output logic rx_en_o
);
  assign tx_en_o = en_i & tx_sel_i;
  assign rx_en_o = en_i & ~tx_sel_i;
endmodule

// File: rtl/tone_gate_gen.sv
module tone_gate_gen #(
  parameter int unsigned CLK_HZ      = 44_000_000,
  parameter int unsigned TONE_HZ     = 22_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tone_force_i,
  input  logic tx_sel_i,
  input  logic key_i,
  output logic tone_o,
  output logic tx_port_en_o,
  output logic rx_port_en_o
);
  import tone_pkg::*;

  localparam int unsigned HALF_CYC = half_cycles(CLK_HZ, TONE_HZ);

  logic key_s_w;
  logic gate_w;
  logic restart_w;

  tone_key_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .key_i   (key_i),
    .key_s_o (key_s_w)
  );

  assign gate_w = gate_open(en_i, tx_sel_i, tone_force_i, key_s_w);

  tone_divider #(.HALF(HALF_CYC)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gate_i    (gate_w),
    .restart_o (restart_w),
    .tone_o    (tone_o)
  );

  tone_port_steer u_steer (
    .en_i     (en_i),
    .tx_sel_i (tx_sel_i),
    .tx_en_o  (tx_port_en_o),
    .rx_en_o  (rx_port_en_o)
  );
endmodule

// File: rtl/tone_gate_chk.sv
module tone_gate_chk #(
  parameter int unsigned HALF = 1000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic tx_sel_i,
  input logic gate_w,
  input logic restart_w,
  input logic tone_o,
  input logic tx_port_en_o,
  input logic rx_port_en_o
);
  int unsigned hi_run;
  int unsigned lo_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run <= 0;
      lo_run <= 0;
    end else begin
      hi_run <= tone_o ? hi_run + 1 : 0;
      lo_run <= (gate_w && !tone_o) ? lo_run + 1 : 0;
    end
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) tone_in_reset_chk: assert (!tone_o);
  end

  // R2
  hi_run_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tone_o |-> hi_run < HALF);

  // R2
  lo_run_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_w && !tone_o) |-> lo_run < HALF);

  // R2
  full_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(tone_o) && gate_w) |-> hi_run == HALF);

  // R6
  burst_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_w ##1 gate_w) |-> tone_o);

  // R7
  gate_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(gate_w) |-> !tone_o);

  // R8
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!tone_o && !tx_port_en_o && !rx_port_en_o));

  // R9
  rx_no_tone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_sel_i |-> !tone_o);

  // R9
  one_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (tx_port_en_o != rx_port_en_o));
endmodule

bind tone_gate_gen tone_gate_chk #(.HALF(HALF_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .tx_sel_i     (tx_sel_i),
  .gate_w       (gate_w),
  .restart_w    (restart_w),
  .tone_o       (tone_o),
  .tx_port_en_o (tx_port_en_o),
  .rx_port_en_o (rx_port_en_o)
);

// File: tb/tb_tone_gate_gen.sv
`timescale 1ns/1ps
module tb_tone_gate_gen;
  localparam int CLK_HZ  = 200;
  localparam int TONE_HZ = 20;
  localparam int H = (CLK_HZ + TONE_HZ) / (2 * TONE_HZ); // R3: 5

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, frc = 1'b0, txs = 1'b0, key = 1'b0;
  logic tone, txe, rxe;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  tone_gate_gen #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tone_force_i(frc),
    .tx_sel_i(txs), .key_i(key), .tone_o(tone),
    .tx_port_en_o(txe), .rx_port_en_o(rxe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 tone in reset", tone, 0);
    chk("R1 tx in reset", txe, 0);
    chk("R1 rx in reset", rxe, 0);
    en = 1'b1; txs = 1'b1; frc = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 tone held in reset", tone, 0);
    en = 1'b0; txs = 1'b0; frc = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4 R5 R8 R9: sweep every control combination and key level
    for (int c = 0; c < 16; c++) begin
      int hi;
      int g;
      en = c[0]; txs = c[1]; frc = c[2]; key = c[3];
      repeat (8) @(negedge clk);
      g = c[0] & c[1] & (c[2] | c[3]);
      chk("R9 tx enable", txe, c[0] & c[1]);
      chk("R9 rx enable", rxe, c[0] & ~c[1]);
      hi = 0;
      for (int i = 0; i < 4 * H; i++) begin
        @(negedge clk);
        hi += tone;
      end
      chk("R2 R8 high cycles in window", hi, g ? 2 * H : 0);
    end

    // R5 R6 R7 R2: every burst length, keyed mode
    en = 1'b1; txs = 1'b1; frc = 1'b0; key = 1'b0;
    repeat (10) @(negedge clk);
    for (int len = 1; len <= 25; len++) begin
      key = 1'b1;
      for (int i = 1; i <= len + 6; i++) begin
        int e;
        @(negedge clk);
        e = (i >= 3 && i <= len + 1 && (((i - 3) / H) % 2 == 0)) ? 1 : 0;
        chk("R6 R7 burst sample", tone, e);
        if (i == len) key = 1'b0;
      end
      repeat (4) @(negedge clk);
    end

    // R4: forced tone, key toggling must not disturb phase
    en = 1'b0; frc = 1'b1; txs = 1'b1; key = 1'b0;
    repeat (6) @(negedge clk);
    en = 1'b1;
    for (int i = 1; i <= 8 * H; i++) begin
      @(negedge clk);
      chk("R4 forced carrier", tone, (((i - 1) / H) % 2 == 0) ? 1 : 0);
      key = ((i % 3) == 0) ? ~key : key;
    end

    // R3: measured period equals computed half-period twice
    begin
      int rises = 0;
      int first = 0;
      int last = 0;
      logic prev = tone;
      for (int i = 0; i < 6 * H; i++) begin
        @(negedge clk);
        if (tone && !prev) begin
          if (rises == 0) first = i; else last = i;
          rises++;
        end
        prev = tone;
      end
      chk("R3 period", (last - first) / (rises - 1), 2 * H);
    end

    // R8: disable silences immediately
    en = 1'b0;
    #0.5;
    chk("R8 tone off", tone, 0);
    chk("R8 tx off", txe, 0);
    chk("R8 rx off", rxe, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule